// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End

This block is the slave-side front end of a two-wire serial bus. It runs on a system clock that is much faster than the bus clock. Both bus lines pass through a synchronizer and a counter-based glitch filter. The block then detects start and stop conditions and shifts in an address byte. That byte carries a fixed device type in its upper nibble and four pin-strapped bits in its lower nibble, and it has no read/write bit. The block acknowledges the address by pulling SDA low through an open-drain output. It then hands the command byte to a command executor, and hands over one data byte when the command calls for one.

A read command makes the block shift out a byte that the executor supplies. A step command turns each later complete SCL pulse into an up or down step request. While the executor reports that a nonvolatile write is in progress, the block does not acknowledge its address, so the master can poll with repeated address bytes until the device answers.

Top module: `tw_slave_fe`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any bit position discards the partial byte and begins a new address byte. A stop at any point returns the block to idle.
- R2: The address byte is sent most significant bit first. It matches only when bits 7..4 are 0101 and bits 3..0 equal `dev_addr_i[3:0]`, with bit 3 on the wire first. On a match the block pulls SDA low from the fall of the eighth SCL until the fall of the ninth.
- R3: On an address mismatch the block gives no acknowledge, and it reports and acknowledges nothing more until the next start.
- R4: While `nv_busy_i` is high when the eighth address bit is sampled, a matching address is not acknowledged. Once busy clears, a new start with the same address is acknowledged.
- R5: The byte after an acknowledged address is the command byte. It is acknowledged and reported once on `cmd_byte_o`, with a single-cycle `cmd_valid_o` pulse.
- R6: Commands whose upper nibble is 1010 or 1100 take one data byte. That byte is acknowledged and reported on `wr_byte_o` with a single-cycle `wr_valid_o` pulse. Any later byte is not acknowledged.
- R7: Commands whose upper nibble is 1001 or 1011 are reads. After the command acknowledge, the block drives `rd_byte_i` most significant bit first. Each bit is placed only after SCL falls, and SDA is released for the master's ninth clock.
- R8: The command with upper nibble 0010 is the step command. After its acknowledge, every complete SCL pulse (rise then fall) produces one `step_valid_o` pulse. `step_up_o` equals the SDA level seen at that pulse's rising edge. A pulse cut short by a stop produces no step.
- R9: Every other command is acknowledged and reported. No data byte after it is acknowledged or reported.
- R10: Clock activity on the bus before any start condition is ignored: no acknowledge and no report.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on bit reception or on start and stop detection.
- R12: `sda_pull_o` high means drive SDA low, and low means release it. The output is low after reset and changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| dev_addr_i | input | 4 | Pin-strapped device address bits |
| nv_busy_i | input | 1 | Executor reports a nonvolatile write in progress |
| rd_byte_i | input | 8 | Byte to send for a read command, valid from `cmd_valid_o` on |
| sda_pull_o | output | 1 | Open-drain control: 1 pulls SDA low |
| cmd_valid_o | output | 1 | One-cycle pulse: command byte received |
| cmd_byte_o | output | 8 | Last received command byte |
| wr_valid_o | output | 1 | One-cycle pulse: data byte received |
| wr_byte_o | output | 8 | Last received data byte |
| step_valid_o | output | 1 | One-cycle pulse: one wiper step requested |
| step_up_o | output | 1 | Direction of the step, 1 is up |

## Verification
A wrong state in this block shows up at the ports within one bus bit. A mistaken acknowledge decision appears as SDA low, or not low, during the ninth clock of that same byte. A lost or extra bit-counter step shifts every later byte by one position, which the bench sees as a corrupted command or data value and as an acknowledge in the wrong clock. A filter that lets a glitch through shows as a spurious start, a spurious stop or an extra bit inside the byte that carries the glitch.

// File: rtl/tw_fe_pkg.sv
`timescale 1ns/1ps
package tw_fe_pkg;

    localparam int          BYTE_W   = 8;
    localparam int          CNT_W    = $clog2(BYTE_W);
    localparam logic [3:0]  DEV_TYPE = 4'b0101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_STEP,
        ST_HOLD
    } fe_state_t;

    typedef enum logic [1:0] {
        CK_SHORT,
        CK_READ,
        CK_WRITE,
        CK_STEP
    } cmd_kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // What follows the command acknowledge, from the opcode nibble
    function automatic cmd_kind_t classify(input logic [BYTE_W-1:0] c);
        cmd_kind_t k;
        case (c[BYTE_W-1 -: 4])
            4'b1001, 4'b1011: k = CK_READ;
            4'b1010, 4'b1100: k = CK_WRITE;
            4'b0010:          k = CK_STEP;
            default:          k = CK_SHORT;
        endcase
        return k;
    endfunction

    function automatic logic addr_hit(input logic [BYTE_W-1:0] a,
                                      input logic [3:0]        pins);
        return (a[BYTE_W-1 -: 4] == DEV_TYPE) && (a[3:0] == pins);
    endfunction

endpackage

// File: rtl/tw_deglitch.sv
`timescale 1ns/1ps
module tw_deglitch #(
    parameter int   LEN     = 5,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // A new level is taken only after LEN consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {2{RST_VAL}};
            run_q  <= '0;
            dout   <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] != dout) begin
                if (run_q == CW'(LEN - 1)) begin
                    dout  <= sync_q[1];
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/tw_cond_detect.sv
`timescale 1ns/1ps
module tw_cond_detect
    import tw_fe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
        ev.sda   = sda_f;
    end
endmodule

// File: rtl/tw_slave_fe.sv
`timescale 1ns/1ps
module tw_slave_fe
    import tw_fe_pkg::*;
#(
    parameter int FILT_LEN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [3:0]        dev_addr_i,
    input  logic              nv_busy_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              sda_pull_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_byte_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              step_valid_o,
    output logic              step_up_o
);
    localparam int LINES = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [LINES-1:0] line_raw, line_flt;
    logic             scl_f, sda_f;
    bus_ev_t          ev;

    fe_state_t        state;
    cmd_kind_t        kind;
    logic [CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] nxt;
    logic             ack_ph;
    logic             step_dir;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_flt
        tw_deglitch #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[g]),
            .dout (line_flt[g])
        );
    end

    assign scl_f = line_flt[1];
    assign sda_f = line_flt[0];

    tw_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .ev    (ev)
    );

    assign nxt = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        cmd_valid_o  <= 1'b0;
        wr_valid_o   <= 1'b0;
        step_valid_o <= 1'b0;
        if (rst) begin
            state      <= ST_IDLE;
            kind       <= CK_SHORT;
            bitcnt     <= '0;
            shreg      <= '0;
            ack_ph     <= 1'b0;
            step_dir   <= 1'b0;
            sda_pull_o <= 1'b0;
            cmd_byte_o <= '0;
            wr_byte_o  <= '0;
            step_up_o  <= 1'b0;
        end else if (ev.start) begin
            state      <= ST_ADDR;
            bitcnt     <= '0;
            ack_ph     <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (ev.stop) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            ack_ph     <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (ev.rise) begin
                        shreg  <= nxt;
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                state <= (addr_hit(nxt, dev_addr_i) && !nv_busy_i)
                                         ? ST_ADDR_ACK : ST_IDLE;
                            end else if (state == ST_CMD) begin
                                cmd_byte_o  <= nxt;
                                cmd_valid_o <= 1'b1;
                                kind        <= classify(nxt);
                                state       <= ST_CMD_ACK;
                            end else begin
                                wr_byte_o  <= nxt;
                                wr_valid_o <= 1'b1;
                                state      <= ST_WDATA_ACK;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (ev.fall) begin
                        if (!ack_ph) begin
                            sda_pull_o <= 1'b1;
                            ack_ph     <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                            ack_ph     <= 1'b0;
                            if (state == ST_ADDR_ACK) begin
                                state <= ST_CMD;
                            end else if (state == ST_WDATA_ACK) begin
                                state <= ST_HOLD;
                            end else begin
                                case (kind)
                                    CK_READ: begin
                                        shreg      <= rd_byte_i;
                                        sda_pull_o <= ~rd_byte_i[BYTE_W-1];
                                        state      <= ST_RDATA;
                                    end
                                    CK_WRITE: state <= ST_WDATA;
                                    CK_STEP:  state <= ST_STEP;
                                    default:  state <= ST_HOLD;
                                endcase
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.fall) begin
                        if (bitcnt == LAST_BIT) begin
                            sda_pull_o <= 1'b0;
                            bitcnt     <= '0;
                            state      <= ST_HOLD;
                        end else begin
                            bitcnt     <= bitcnt + 1'b1;
                            shreg      <= {shreg[BYTE_W-2:0], shreg[BYTE_W-1]};
                            sda_pull_o <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_STEP: begin
                    if (ev.rise) begin
                        step_dir <= ev.sda;
                    end
                    if (ev.fall) begin
                        step_valid_o <= 1'b1;
                        step_up_o    <= step_dir;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tw_slave_fe_chk.sv
`timescale 1ns/1ps
module tw_slave_fe_chk
    import tw_fe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input fe_state_t        state,
    input logic             ev_start,
    input logic             ev_stop,
    input logic             ev_rise,
    input logic [CNT_W-1:0] bitcnt,
    input logic             scl_f,
    input logic             nv_busy_i,
    input logic             sda_pull_o,
    input logic             cmd_valid_o,
    input logic             wr_valid_o,
    input logic             step_valid_o
);
    p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_f);

    p_start_restart_r1: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (state == ST_ADDR) && (bitcnt == '0));

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (state == ST_IDLE) && !sda_pull_o);

    p_busy_no_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) && ev_rise && (bitcnt == CNT_W'(BYTE_W - 1)) && nv_busy_i
        |=> state == ST_IDLE);

    p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid_o, wr_valid_o, step_valid_o}));

    p_cmd_then_ack_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> state == ST_CMD_ACK);

    p_step_in_step_r8: assert property (@(posedge clk) disable iff (rst)
        step_valid_o |-> $past(state) == ST_STEP);
endmodule

bind tw_slave_fe tw_slave_fe_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .state        (state),
    .ev_start     (ev.start),
    .ev_stop      (ev.stop),
    .ev_rise      (ev.rise),
    .bitcnt       (bitcnt),
    .scl_f        (scl_f),
    .nv_busy_i    (nv_busy_i),
    .sda_pull_o   (sda_pull_o),
    .cmd_valid_o  (cmd_valid_o),
    .wr_valid_o   (wr_valid_o),
    .step_valid_o (step_valid_o)
);

// File: tb/tw_slave_fe_test.sv
`timescale 1ns/1ps
module tw_slave_fe_test;
    localparam int Q  = 20;   // system clocks per bus quarter phase
    localparam int FL = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] pins  = 4'h0;
    logic       busy  = 1'b0;
    logic [7:0] rd_val = 8'h00;
    logic       sda_line;

    logic       sda_pull, cmd_valid, wr_valid, step_valid, step_up;
    logic [7:0] cmd_byte, wr_byte;

    assign sda_line = sda_m & ~sda_pull;

    tw_slave_fe #(.FILT_LEN(FL)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .dev_addr_i(pins), .nv_busy_i(busy), .rd_byte_i(rd_val),
        .sda_pull_o(sda_pull), .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
        .wr_valid_o(wr_valid), .wr_byte_o(wr_byte),
        .step_valid_o(step_valid), .step_up_o(step_up)
    );

    int n_chk = 0, n_fail = 0;
    int n_cmd = 0, n_wr = 0, n_up = 0, n_dn = 0;
    logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid)  begin n_cmd++; last_cmd = cmd_byte; end
            if (wr_valid)   begin n_wr++;  last_wr  = wr_byte;  end
            if (step_valid) begin if (step_up) n_up++; else n_dn++; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q/2);
        s = sda_line; tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    // Same bit with a short SCL pulse in the low phase and, for a 1, a short SDA dip while SCL is high
    task automatic glitch_bit(input logic b, output logic s);
        sda_m = b;    tick(Q/2);
        scl_m = 1'b1; tick(FL-2);
        scl_m = 1'b0; tick(Q/2);
        scl_m = 1'b1; tick(Q/4);
        if (b) begin sda_m = 1'b0; tick(FL-2); sda_m = 1'b1; end
        tick(Q/4);
        s = sda_line; tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); v[i] = s; end
        clock_bit(~mack, s);
    endtask

    function automatic logic [7:0] addr_of(input logic [3:0] p);
        return {4'b0101, p};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a0, a1, a2, s;
        logic [7:0] got;
        int c0, w0, u0, d0;
        void'($urandom(32'd4242));
        tick(10);
        rst = 1'b0;
        tick(5);
        chk("R12 reset pull", sda_pull, 0);
        chk("R12 reset pulses", {cmd_valid, wr_valid, step_valid}, 0);

        // R10: bytes clocked with no start
        pins = 4'h9;
        scl_m = 1'b0; tick(Q);
        send_byte(addr_of(4'h9), a0);
        send_byte(8'hA4, a1);
        chk("R10 no ack before start", {a0, a1}, 0);
        chk("R10 no command before start", n_cmd, 0);
        bus_stop();

        // R2 R5 R6: directed write
        bus_start();
        send_byte(addr_of(4'h9), a0);
        send_byte(8'hA4, a1);
        send_byte(8'h2B, a2);
        bus_stop();
        chk("R2 address ack", a0, 1);
        chk("R5 command ack and value", {a1, last_cmd}, {1'b1, 8'hA4});
        chk("R6 data ack and value", {a2, last_wr, 8'(n_wr)}, {1'b1, 8'h2B, 8'd1});

        // R2 bit order, R3 mismatch
        pins = 4'h8;
        c0 = n_cmd;
        bus_start();
        send_byte(addr_of(4'h1), a0);
        send_byte(8'hA0, a1);
        bus_stop();
        chk("R2 pin order mismatch no ack", {a0, a1}, 0);
        bus_start();
        send_byte(8'h68, a0);
        send_byte(8'hA0, a1);
        bus_stop();
        chk("R3 wrong type no ack", {a0, a1}, 0);
        chk("R3 no command reported", n_cmd, c0);

        // R4 busy polling, then R9 short command
        busy = 1'b1;
        bus_start();
        send_byte(addr_of(4'h8), a0);
        bus_stop();
        chk("R4 busy address not acked", a0, 0);
        busy = 1'b0;
        w0 = n_wr;
        bus_start();
        send_byte(addr_of(4'h8), a0);
        send_byte(8'hD6, a1);
        send_byte(8'h55, a2);
        bus_stop();
        chk("R4 ack once ready", a0, 1);
        chk("R9 short command acked", {a1, last_cmd}, {1'b1, 8'hD6});
        chk("R9 no data byte taken", {a2, 8'(n_wr - w0)}, 0);

        // R7 reads
        rd_val = 8'hC5;
        bus_start();
        send_byte(addr_of(4'h8), a0);
        send_byte(8'hB6, a1);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R7 read data register", {a0, a1, got}, {2'b11, 8'hC5});
        rd_val = 8'h3A;
        bus_start();
        send_byte(addr_of(4'h8), a0);
        send_byte(8'h94, a1);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R7 read wiper", got, 8'h3A);

        // R8 steps: three up, one down, then a stop pulse that must not count
        u0 = n_up; d0 = n_dn;
        bus_start();
        send_byte(addr_of(4'h8), a0);
        send_byte(8'h24, a1);
        clock_bit(1'b1, s); clock_bit(1'b1, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
        bus_stop();
        chk("R8 up steps", n_up - u0, 3);
        chk("R8 down steps, stop pulse excluded", n_dn - d0, 1);

        // R1 abort by repeated start mid-byte, and by stop mid-byte
        c0 = n_cmd;
        bus_start();
        clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s);
        bus_start();
        send_byte(addr_of(4'h8), a0);
        send_byte(8'hC3, a1);
        send_byte(8'h77, a2);
        bus_stop();
        chk("R1 restart mid byte", {a0, a1, a2, last_cmd, last_wr}, {3'b111, 8'hC3, 8'h77});
        bus_start();
        send_byte(addr_of(4'h8), a0);
        clock_bit(1'b1, s); clock_bit(1'b0, s);
        bus_stop();
        chk("R1 stop mid byte aborts", n_cmd - c0, 1);

        // R11 glitches on both lines inside the command byte
        bus_start();
        send_byte(addr_of(4'h8), a0);
        for (int i = 7; i >= 0; i--) glitch_bit(8'hA7 >> i, s);
        clock_bit(1'b1, s); a1 = ~s;
        send_byte(8'h19, a2);
        bus_stop();
        chk("R11 glitches ignored", {a1, a2, last_cmd, last_wr}, {2'b11, 8'hA7, 8'h19});

        // Random transfers
        for (int it = 0; it < 16; it++) begin
            int k, len;
            logic [7:0] d, cmd;
            logic [5:0] pat;
            int ups;
            k = $urandom % 5;
            pins = 4'($urandom);
            d = 8'($urandom);
            c0 = n_cmd; w0 = n_wr; u0 = n_up; d0 = n_dn;
            bus_start();
            case (k)
                0: begin
                    cmd = {(($urandom % 2) != 0) ? 4'hA : 4'hC, 1'b0, 3'($urandom)};
                    send_byte(addr_of(pins), a0);
                    send_byte(cmd, a1);
                    send_byte(d, a2);
                    bus_stop();
                    chk("R6 random write", {a0, a1, a2, last_cmd, last_wr, 8'(n_wr - w0)},
                        {3'b111, cmd, d, 8'd1});
                end
                1: begin
                    cmd = {(($urandom % 2) != 0) ? 4'h9 : 4'hB, 1'b0, 3'($urandom)};
                    rd_val = d;
                    send_byte(addr_of(pins), a0);
                    send_byte(cmd, a1);
                    recv_byte(got, 1'b0);
                    bus_stop();
                    chk("R7 random read", {a0, a1, got, last_cmd}, {2'b11, d, cmd});
                end
                2: begin
                    case ($urandom % 4)
                        0: cmd = 8'hD0;
                        1: cmd = 8'hE0;
                        2: cmd = 8'h10;
                        default: cmd = 8'h80;
                    endcase
                    cmd[2:0] = 3'($urandom);
                    send_byte(addr_of(pins), a0);
                    send_byte(cmd, a1);
                    send_byte(d, a2);
                    bus_stop();
                    chk("R9 random short", {a0, a1, a2, last_cmd, 8'(n_wr - w0)},
                        {3'b110, cmd, 8'd0});
                end
                3: begin
                    logic [7:0] bad;
                    if (($urandom % 2) != 0) bad = {4'b0101, pins ^ 4'(1 + $urandom % 15)};
                    else                     bad = {4'b0111, pins};
                    send_byte(bad, a0);
                    send_byte(8'hA0, a1);
                    bus_stop();
                    chk("R3 random mismatch", {a0, a1, 8'(n_cmd - c0)}, 0);
                end
                default: begin
                    len = 1 + $urandom % 6;
                    pat = 6'($urandom);
                    ups = 0;
                    send_byte(addr_of(pins), a0);
                    send_byte(8'h20, a1);
                    for (int j = 0; j < len; j++) begin
                        clock_bit(pat[j], s);
                        if (pat[j]) ups++;
                    end
                    bus_stop();
                    chk("R8 random steps", {n_up - u0, n_dn - d0}, {ups, len - ups});
                end
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule